// File: doc/BRIEF.md
# Fill-Word Elastic Buffer

This block sits between a recovered receive clock and the local core clock on a serial link receiver. Decoded 32-bit words arrive on the write side, one per write-clock cycle when valid. Each word carries a control flag and a fill flag. The read side hands words to the core at its own rate, one per cycle in which it asks for one. The two clocks may differ slightly in frequency. The block absorbs that drift by adjusting the number of fill words that sit between frames. It never touches frame words.

Drift in one direction raises occupancy. The write side then discards surplus fill words of the gap being received. It does this only while enough fill words of that gap are already stored for the receiver to still recognise a gap. Drift in the other direction lowers occupancy. The read side then repeats the fill word it just delivered instead of advancing. If the store still fills up or runs dry, the word in question is lost and a sticky flag is raised in the domain that saw it.

The two pointers cross between the clocks in Gray code through synchroniser stages. Each side computes occupancy from its own pointer and the synchronised copy of the other pointer.

Top module: `fwb_elastic`

## Requirements
- R1: While a reset is held and after it is released, `rd_valid`, `overrun` and `underrun` are 0, and the store holds no words.
- R2: Every stored word with `wr_fill` = 0 (a frame word) reaches the read port exactly once, in write order. Rate adjustment never removes or repeats a frame word.
- R3: An incoming fill word (`wr_fill` = 1) is discarded only when both of these hold: write-side occupancy is above HI_WM (default 12), and at least MIN_GAP (default 3) fill words of the current gap are already stored. Frame words are never discarded for occupancy reasons.
- R4: When each input gap holds at least 6 fill words, every gap between frame words at the read port holds at least MIN_GAP fill words.
- R5: A word is repeated when `rd_en` is high, the last delivered word had `rd_fill` = 1, and read-side occupancy is below LO_WM (default 4). In that case the block delivers that same word again and does not advance. A store holding only fill words can therefore be read indefinitely.
- R6: A word arriving while the store holds DEPTH (16) words is dropped, unless R3 discards it, and `overrun` is set. `overrun` stays set until reset.
- R7: If `rd_en` is high, the store is empty and no repeat applies, `rd_valid` stays 0 in the following cycle and `underrun` is set. `underrun` stays set until reset.
- R8: `rd_valid` is 1 only in the read-clock cycle after an edge at which `rd_en` was 1 and a word was delivered. It is 1 for exactly one cycle per delivered word.
- R9: When the two sides move words at the same rate, no fill words are added or removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Word present on the write side this cycle |
| wr_data | input | 32 | Decoded word |
| wr_ctrl | input | 1 | Word carries a control character |
| wr_fill | input | 1 | Word is an inter-frame fill word |
| rd_clk | input | 1 | Local core clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Core requests a word this cycle |
| rd_valid | output | 1 | Delivered word is on the read outputs |
| rd_data | output | 32 | Delivered word |
| rd_ctrl | output | 1 | Control flag of the delivered word |
| rd_fill | output | 1 | Fill flag of the delivered word |
| overrun | output | 1 | Sticky: a word was lost to a full store (write domain) |
| underrun | output | 1 | Sticky: a read found nothing to deliver (read domain) |

## Verification
On the read side, repeating a fill word and fetching the next stored word compete in the same cycle. This happens when occupancy is low just as a frame word has landed behind a gap. The same clash occurs on the write side when the watermark deletion and a full store meet on one arriving fill word. A writer that skips every fourth cycle against a reader that never does drives the read side into repeats at frame boundaries. The reverse duty drives the write side into deletions near full. Each case is judged on the captured read stream: frame words must appear once, in order, with gaps never under three fill words, and the fill count must move in the expected direction.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    localparam int FWB_DEPTH = 16;
    localparam int FWB_AW    = $clog2(FWB_DEPTH);
    localparam int FWB_PW    = FWB_AW + 1;
    localparam int FWB_DW    = 32;

    typedef logic [FWB_PW-1:0] fwb_ptr_t;
    typedef logic [FWB_AW-1:0] fwb_addr_t;

    typedef struct packed {
        logic [FWB_DW-1:0] data;
        logic              ctrl;
        logic              fill;
    } fwb_word_t;

    function automatic fwb_ptr_t fwb_bin2gray(input fwb_ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic fwb_ptr_t fwb_gray2bin(input fwb_ptr_t g);
        fwb_ptr_t b;
        b[FWB_PW-1] = g[FWB_PW-1];
        for (int i = FWB_PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fwb_ptr_sync.sv
module fwb_ptr_sync
    import fwb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  fwb_ptr_t gray_in,
    output fwb_ptr_t bin_out
);

    fwb_ptr_t pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '0;
                    else     pipe[0] <= gray_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign bin_out = fwb_gray2bin(pipe[STAGES-1]);

endmodule

// File: rtl/fwb_wr_ctrl.sv
module fwb_wr_ctrl
    import fwb_pkg::*;
#(
    parameter int HI_WM   = 12,
    parameter int MIN_GAP = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  fwb_word_t in_word,
    input  fwb_ptr_t  rd_bin_sync,
    output logic      we,
    output fwb_addr_t waddr,
    output fwb_word_t wdata,
    output fwb_ptr_t  wr_gray,
    output logic      overrun
);

    localparam int KW = (MIN_GAP < 1) ? 1 : $clog2(MIN_GAP + 1);
    localparam fwb_ptr_t       HI_LVL   = fwb_ptr_t'(HI_WM);
    localparam fwb_ptr_t       FULL_LVL = fwb_ptr_t'(FWB_DEPTH);
    localparam fwb_ptr_t       PTR_ONE  = fwb_ptr_t'(1);
    localparam logic [KW-1:0]  GAP_LVL  = KW'(MIN_GAP);

    fwb_ptr_t      wr_bin;
    fwb_ptr_t      wr_bin_nxt;
    fwb_ptr_t      occ;
    logic [KW-1:0] kept;
    logic          full;
    logic          drop_fill;
    logic          store;
    logic          clash;

    always_comb begin
        occ        = wr_bin - rd_bin_sync;
        full       = (occ == FULL_LVL);
        drop_fill  = in_valid && in_word.fill && (occ > HI_LVL) && (kept >= GAP_LVL);
        store      = in_valid && !full && !drop_fill;
        clash      = in_valid && full && !drop_fill;
        wr_bin_nxt = store ? (wr_bin + PTR_ONE) : wr_bin;
    end

    assign we    = store;
    assign waddr = wr_bin[FWB_AW-1:0];
    assign wdata = in_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            kept    <= '0;
            overrun <= 1'b0;
        end else begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= fwb_bin2gray(wr_bin_nxt);
            if (clash) overrun <= 1'b1;
            if (in_valid) begin
                if (!in_word.fill)                   kept <= '0;
                else if (store && (kept < GAP_LVL))  kept <= kept + KW'(1);
            end
        end
    end

    // R2: a frame word meeting free space is always stored
    p_frame_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_word.fill && !full) |=> (wr_bin == $past(wr_bin) + PTR_ONE));

    // R3: no deletion while occupancy is at or below the high watermark
    p_delete_watermark_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full && (occ <= HI_LVL)) |=> (wr_bin == $past(wr_bin) + PTR_ONE));

    // R4: the first fill words of a gap are always kept
    p_gap_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word.fill && (kept < GAP_LVL) && !full) |=> (wr_bin == $past(wr_bin) + PTR_ONE));

    // R6: occupancy never exceeds the depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_LVL);

    // R6: overrun is sticky
    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/fwb_rd_ctrl.sv
module fwb_rd_ctrl
    import fwb_pkg::*;
#(
    parameter int LO_WM = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_en,
    input  fwb_ptr_t  wr_bin_sync,
    input  fwb_word_t mem_word,
    output fwb_addr_t raddr,
    output logic      out_valid,
    output fwb_word_t out_word,
    output fwb_ptr_t  rd_gray,
    output logic      underrun
);

    localparam fwb_ptr_t LO_LVL  = fwb_ptr_t'(LO_WM);
    localparam fwb_ptr_t PTR_ONE = fwb_ptr_t'(1);

    fwb_ptr_t rd_bin;
    fwb_ptr_t occ;
    logic     empty;
    logic     repeat_fill;
    logic     fetch;
    logic     starve;

    always_comb begin
        occ         = wr_bin_sync - rd_bin;
        empty       = (occ == '0);
        repeat_fill = rd_en && out_word.fill && (occ < LO_LVL);
        fetch       = rd_en && !repeat_fill && !empty;
        starve      = rd_en && !repeat_fill && empty;
    end

    assign raddr = rd_bin[FWB_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin    <= '0;
            rd_gray   <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            out_valid <= repeat_fill || fetch;
            if (fetch) begin
                out_word <= mem_word;
                rd_bin   <= rd_bin + PTR_ONE;
                rd_gray  <= fwb_bin2gray(rd_bin + PTR_ONE);
            end
            if (starve) underrun <= 1'b1;
        end
    end

    // R5: a repeat delivers the same word again without advancing
    p_insert_repeat_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && out_word.fill && (occ < LO_LVL)) |=> (out_valid && $stable(out_word) && $stable(rd_bin)));

    // R2: a frame word already delivered is never followed by a repeat of itself
    p_frame_once_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty && !out_word.fill) |=> (rd_bin == $past(rd_bin) + PTR_ONE));

    // R7: a read with nothing to give raises underrun and no valid
    p_starve_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !out_word.fill) |=> (!out_valid && underrun));

    // R7: underrun is sticky
    p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R8: no delivery without a request
    p_valid_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !out_valid);

endmodule

// File: rtl/fwb_elastic.sv
module fwb_elastic
    import fwb_pkg::*;
#(
    parameter int HI_WM       = 12,
    parameter int LO_WM       = 4,
    parameter int MIN_GAP     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_valid,
    input  logic [FWB_DW-1:0] wr_data,
    input  logic              wr_ctrl,
    input  logic              wr_fill,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [FWB_DW-1:0] rd_data,
    output logic              rd_ctrl,
    output logic              rd_fill,
    output logic              overrun,
    output logic              underrun
);

    fwb_word_t in_word;
    fwb_word_t wdata;
    fwb_word_t mem_word;
    fwb_word_t out_word;
    fwb_addr_t waddr;
    fwb_addr_t raddr;
    fwb_ptr_t  wr_gray;
    fwb_ptr_t  rd_gray;
    fwb_ptr_t  wr_bin_rd;
    fwb_ptr_t  rd_bin_wr;
    logic      we;

    fwb_word_t store_mem [FWB_DEPTH];

    assign in_word = '{data: wr_data, ctrl: wr_ctrl, fill: wr_fill};

    always_ff @(posedge wr_clk) begin
        if (we) store_mem[waddr] <= wdata;
    end

    assign mem_word = store_mem[raddr];

    fwb_wr_ctrl #(.HI_WM(HI_WM), .MIN_GAP(MIN_GAP)) u_wr (
        .clk         (wr_clk),
        .rst         (wr_rst),
        .in_valid    (wr_valid),
        .in_word     (in_word),
        .rd_bin_sync (rd_bin_wr),
        .we          (we),
        .waddr       (waddr),
        .wdata       (wdata),
        .wr_gray     (wr_gray),
        .overrun     (overrun)
    );

    fwb_ptr_sync #(.STAGES(SYNC_STAGES)) u_rd2wr (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .gray_in (rd_gray),
        .bin_out (rd_bin_wr)
    );

    fwb_ptr_sync #(.STAGES(SYNC_STAGES)) u_wr2rd (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .gray_in (wr_gray),
        .bin_out (wr_bin_rd)
    );

    fwb_rd_ctrl #(.LO_WM(LO_WM)) u_rd (
        .clk         (rd_clk),
        .rst         (rd_rst),
        .rd_en       (rd_en),
        .wr_bin_sync (wr_bin_rd),
        .mem_word    (mem_word),
        .raddr       (raddr),
        .out_valid   (rd_valid),
        .out_word    (out_word),
        .rd_gray     (rd_gray),
        .underrun    (underrun)
    );

    assign rd_data = out_word.data;
    assign rd_ctrl = out_word.ctrl;
    assign rd_fill = out_word.fill;

endmodule

// File: tb/fwb_elastic_test.sv
module fwb_elastic_test;

    localparam int          PERIODS = 12;
    localparam int          CAP     = 1024;
    localparam logic [31:0] IDLE_W  = 32'h1DAE_0001;
    localparam logic [31:0] ARB_W   = 32'hA4B0_00FF;
    localparam logic [31:0] FRM_W   = 32'hF000_0000;

    // row: [3] writer skips every 4th cycle, [2] reader skips every 4th cycle,
    //      [1:0] expected fill change: 0 none, 1 fewer, 2 more
    localparam logic [3:0] SCEN_TAB [0:2] = '{4'b0000, 4'b0101, 4'b1010};

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst = 1'b1;
    logic        rd_rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ctrl = 1'b0;
    logic        wr_fill = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_ctrl;
    logic        rd_fill;
    logic        overrun;
    logic        underrun;

    int          n_checks = 0;
    int          n_fail   = 0;
    int          wcyc;
    int          cap_n;
    logic [31:0] cap_data [0:CAP-1];
    logic        cap_fill [0:CAP-1];
    bit          wr_done;
    bit          rd_done;

    fwb_elastic uut (
        .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_valid (wr_valid),
        .wr_data (wr_data), .wr_ctrl (wr_ctrl), .wr_fill (wr_fill),
        .rd_clk (rd_clk), .rd_rst (rd_rst), .rd_en (rd_en),
        .rd_valid (rd_valid), .rd_data (rd_data), .rd_ctrl (rd_ctrl),
        .rd_fill (rd_fill), .overrun (overrun), .underrun (underrun)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_rst = 1'b1; rd_rst = 1'b1; wr_valid = 1'b0; rd_en = 1'b0;
        repeat (4) @(negedge wr_clk);
        wr_rst = 1'b0; rd_rst = 1'b0;
        repeat (2) @(negedge wr_clk);
        wcyc = 0; cap_n = 0; wr_done = 0; rd_done = 0;
    endtask

    task automatic put(input logic [31:0] d, input logic c, input logic f, input bit gap);
        while (1) begin
            @(negedge wr_clk);
            if (gap && (wcyc % 4 == 3)) begin
                wr_valid = 1'b0;
                wcyc++;
            end else begin
                wr_valid = 1'b1; wr_data = d; wr_ctrl = c; wr_fill = f;
                wcyc++;
                break;
            end
        end
    endtask

    task automatic writer(input bit gap);
        int seq = 0;
        for (int p = 0; p < PERIODS; p++) begin
            for (int i = 0; i < 6; i++) put((p % 2) ? ARB_W : IDLE_W, 1'b1, 1'b1, gap);
            for (int i = 0; i < 4; i++) begin
                put(FRM_W | seq, (i == 0), 1'b0, gap);
                seq++;
            end
        end
        for (int i = 0; i < 6; i++) put(IDLE_W, 1'b1, 1'b1, gap);
        @(negedge wr_clk);
        wr_valid = 1'b0;
        wr_done = 1;
    endtask

    task automatic reader(input bit gap);
        int rcyc = 0;
        int tail = 0;
        repeat (8) @(negedge rd_clk);
        while (!wr_done || tail < 40) begin
            @(negedge rd_clk);
            rd_en = !(gap && (rcyc % 4 == 3));
            rcyc++;
            if (wr_done) tail++;
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
        repeat (3) @(negedge rd_clk);
        rd_done = 1;
    endtask

    task automatic monitor();
        while (!rd_done) begin
            @(negedge rd_clk);
            if (rd_valid && cap_n < CAP) begin
                cap_data[cap_n] = rd_data;
                cap_fill[cap_n] = rd_fill;
                cap_n++;
            end
        end
    endtask

    task automatic read_burst(input int n);
        cap_n = 0; rd_done = 0;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    @(negedge rd_clk);
                    rd_en = 1'b1;
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
                repeat (3) @(negedge rd_clk);
                rd_done = 1;
            end
            monitor();
        join
    endtask

    task automatic run_scen(input logic [3:0] row);
        int frames = 0, mism = 0, run = 0, min_run = 1000;
        int fills = 0, fills_at_last = 0, bad_fill = 0;
        do_reset();
        fork
            writer(row[3]);
            reader(row[2]);
            monitor();
        join
        for (int i = 0; i < cap_n; i++) begin
            if (cap_fill[i]) begin
                run++;
                fills++;
                if (cap_data[i] != IDLE_W && cap_data[i] != ARB_W) bad_fill++;
            end else begin
                if (frames > 0 && run > 0 && run < min_run) min_run = run;
                if (cap_data[i] != (FRM_W | frames)) mism++;
                frames++;
                run = 0;
                fills_at_last = fills;
            end
        end
        check(frames == 4 * PERIODS, "R2", "frame words delivered", frames, 4 * PERIODS);
        check(mism == 0, "R2", "frame words out of order", mism, 0);
        check(min_run >= 3, "R4", "shortest output gap", min_run, 3);
        check(bad_fill == 0, "R5", "fill words with foreign content", bad_fill, 0);
        case (row[1:0])
            2'd1:    check(fills_at_last < 6 * PERIODS, "R3", "fill words after deletion", fills_at_last, 6 * PERIODS);
            2'd2:    check(fills_at_last > 6 * PERIODS, "R5", "fill words after insertion", fills_at_last, 6 * PERIODS);
            default: check(fills_at_last == 6 * PERIODS, "R9", "fill words at equal rates", fills_at_last, 6 * PERIODS);
        endcase
        check(!overrun && !underrun, "R6", "no flag in a compensated stream", {overrun, underrun}, 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int ok;
        // R1: reset state
        repeat (3) @(negedge wr_clk);
        check(rd_valid == 1'b0, "R1", "rd_valid during reset", rd_valid, 0);
        do_reset();
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        check(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);
        check(underrun == 1'b0, "R1", "underrun after reset", underrun, 0);

        // Table walk: balanced, fast writer, slow writer
        for (int s = 0; s < 3; s++) run_scen(SCEN_TAB[s]);

        // R6 / R3: fill the store with frame words only, no reads
        do_reset();
        for (int i = 0; i < 20; i++) put(FRM_W | i, 1'b0, 1'b0, 1'b0);
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat (6) @(negedge wr_clk);
        check(overrun == 1'b1, "R6", "overrun after writing past full", overrun, 1);
        read_burst(18);
        check(cap_n == 16, "R6", "words kept from an overfilled store", cap_n, 16);
        ok = 0;
        for (int i = 0; i < cap_n; i++) if (cap_data[i] == (FRM_W | i) && !cap_fill[i]) ok++;
        check(ok == 16, "R3", "frame words kept above high watermark", ok, 16);
        check(underrun == 1'b1, "R7", "underrun after reading past a frame word", underrun, 1);
        check(overrun == 1'b1, "R6", "overrun still held", overrun, 1);

        // R5 / R7 / R8: a store of fill words only can be drained forever
        do_reset();
        for (int i = 0; i < 5; i++) put(IDLE_W, 1'b1, 1'b1, 1'b0);
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat (6) @(negedge wr_clk);
        read_burst(20);
        check(cap_n == 20, "R8", "one word per request", cap_n, 20);
        ok = 0;
        for (int i = 0; i < cap_n; i++) if (cap_fill[i] && cap_data[i] == IDLE_W) ok++;
        check(ok == 20, "R5", "repeated fill words", ok, 20);
        check(underrun == 1'b0, "R7", "no underrun while repeating", underrun, 0);
        ok = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge rd_clk);
            if (rd_valid) ok++;
        end
        check(ok == 0, "R8", "rd_valid without rd_en", ok, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule